// File: doc/BRIEF.md
# Floppy controller host register bridge

This block connects an 8-bit processor bus to a floppy disk controller core and to one channel of a DMA engine. Processor accesses to the four controller registers (command/status, track, sector, data) are forwarded to the core in the same cycle. Every command write is also classified: head-positioning commands raise a flag, and data-transfer commands start the DMA channel automatically when that channel is armed with a sensible word count and is idle.

The bridge also holds a side-select bit, a DRQ/IRQ flag byte and an interrupt mask. It doubles track numbers written while a double-density disk sits in a single-density drive, and it turns each new DRQ during an active DMA transfer into a one-cycle request pulse. When no controller is fitted (`ctl_present` low), all reads return all ones and writes have no effect.

Register select codes: 0 command (write) / controller status (read), 1 track, 2 sector, 3 data, 4 side, 5 DRQ/IRQ flags, 6 interrupt mask, 7 spare. Reads are registered: `bus_rdata` updates on the clock edge that samples `bus_rd`.

Top module: `fdc_host_bridge`

## Requirements
- R1: A command write (select 0) with bit 7 clear sets `cmd_is_type1` on the next edge; a command write with bit 7 set clears it.
- R2: A command write with a code from 0x80 to 0xCF, or 0xE0 to 0xFF, starts DMA only if `dma_words` is neither 0 nor 0xFFFF and `dma_busy` is low. Any other code or condition starts nothing.
- R3: A DMA start is a one-cycle `dma_fixsrc` pulse in the cycle after the command write, then a one-cycle `dma_start` pulse in the cycle after that.
- R4: Reading select 5 returns the DRQ level in bit 7 and the IRQ level in bit 6, both as latched at the previous clock edge, with bits 5 to 0 reading 1.
- R5: `irq_out` is registered `fdc_irq` AND NOT mask. Reset sets the mask. Writing select 6 loads the mask from bit 0. Reading select 6 returns 0xFE OR mask.
- R6: A rising `fdc_drq`, while `dma_busy` is high, gives exactly one cycle of `dma_xfer`. No pulse is given while `dma_busy` is low.
- R7: A side write (select 4) keeps only bit 0. That bit drives `side_sel`, and reading select 4 returns 0xFE OR the bit.
- R8: A track write (select 1) is forwarded shifted left by one when `media_dd` and `drive_sd` are both high; otherwise it is forwarded unchanged.
- R9: With `ctl_present` low, every read returns 0xFF and no write reaches the controller, side bit, mask or command logic.
- R10: After reset, `cmd_is_type1`, `side_sel`, `irq_out` and the DMA pulses are 0, the latched DRQ/IRQ flags are 0, and `bus_rdata` is 0xFF.
- R11: Selects 0 to 3 are forwarded as controller address 0 to 3, with the write strobe or read strobe in the same cycle as the bus access. Reads of these selects return the controller's read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_present | input | 1 | Controller fitted |
| bus_sel | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| fdc_wr | output | 1 | Controller write strobe |
| fdc_rd | output | 1 | Controller read strobe |
| fdc_addr | output | 2 | Controller register address |
| fdc_wdata | output | 8 | Controller write data (track translated) |
| fdc_rdata | input | 8 | Controller read data |
| fdc_irq | input | 1 | Controller interrupt request |
| fdc_drq | input | 1 | Controller data request |
| dma_words | input | 16 | DMA channel word count |
| dma_busy | input | 1 | DMA channel transferring |
| media_dd | input | 1 | Selected medium is not single density |
| drive_sd | input | 1 | Selected drive is single density |
| dma_fixsrc | output | 1 | Pulse: set fixed source address |
| dma_start | output | 1 | Pulse: start transfer |
| dma_xfer | output | 1 | Pulse: one transfer request |
| irq_out | output | 1 | Masked interrupt |
| cmd_is_type1 | output | 1 | Last command was head positioning |
| side_sel | output | 1 | Side select |

## Verification
Two functions can act in the same cycle. The first case is a flag-byte read in the very cycle that DRQ and IRQ rise. The bench raises both lines and issues the read on the same falling edge. It then expects the old flags from that read and the new flags from the next read. The second case is a DMA-starting command write in the cycle that DRQ rises with the channel busy. Here the bench expects the transfer-request pulse, and it expects the start sequence to be suppressed, because the busy channel disqualifies the start.

// File: rtl/fdcb_pkg.sv
package fdcb_pkg;
  typedef enum logic [2:0] {
    RS_CMD    = 3'd0,
    RS_TRACK  = 3'd1,
    RS_SECTOR = 3'd2,
    RS_DATA   = 3'd3,
    RS_SIDE   = 3'd4,
    RS_FLAGS  = 3'd5,
    RS_MASK   = 3'd6,
    RS_SPARE  = 3'd7
  } regsel_e;

  // Data-transfer command codes that call for an automatic DMA start.
  function automatic logic wants_dma(input logic [7:0] code);
    return ((code >= 8'h80) && (code < 8'hD0)) || (code >= 8'hE0);
  endfunction
endpackage

// File: rtl/fdcb_track_xlat.sv
module fdcb_track_xlat #(
  parameter int DW = 8
) (
  input  logic          is_track,
  input  logic          media_dd,
  input  logic          drive_sd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_comb begin
    if (is_track && media_dd && drive_sd) dout = {din[DW-2:0], 1'b0};
    else                                  dout = din;
  end
endmodule

// File: rtl/fdcb_cmd_decode.sv
module fdcb_cmd_decode import fdcb_pkg::*; #(
  parameter int WCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_we,
  input  logic [7:0]     cmd_val,
  input  logic [WCW-1:0] dma_words,
  input  logic           dma_busy,
  output logic           cmd_is_type1,
  output logic           dma_fixsrc,
  output logic           dma_start
);
  localparam logic [WCW-1:0] WC_FULL = '1;
  localparam logic [WCW-1:0] WC_ZERO = '0;

  logic armed;
  assign armed = (dma_words != WC_ZERO) && (dma_words != WC_FULL) && !dma_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_is_type1 <= 1'b0;
      dma_fixsrc   <= 1'b0;
      dma_start    <= 1'b0;
    end else begin
      if (cmd_we) cmd_is_type1 <= !cmd_val[7];
      dma_fixsrc <= cmd_we && wants_dma(cmd_val) && armed;
      dma_start  <= dma_fixsrc;
    end
  end
endmodule

// File: rtl/fdcb_irq_status.sv
module fdcb_irq_status (
  input  logic clk,
  input  logic rst,
  input  logic fdc_drq,
  input  logic fdc_irq,
  input  logic dma_busy,
  input  logic mask_we,
  input  logic mask_val,
  output logic drq_q,
  output logic irq_q,
  output logic mask_q,
  output logic irq_out,
  output logic dma_xfer
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drq_q    <= 1'b0;
      irq_q    <= 1'b0;
      mask_q   <= 1'b1;
      irq_out  <= 1'b0;
      dma_xfer <= 1'b0;
    end else begin
      drq_q    <= fdc_drq;
      irq_q    <= fdc_irq;
      if (mask_we) mask_q <= mask_val;
      irq_out  <= fdc_irq && !mask_q;
      dma_xfer <= fdc_drq && !drq_q && dma_busy;
    end
  end
endmodule

// File: rtl/fdc_host_bridge.sv
module fdc_host_bridge import fdcb_pkg::*; #(
  parameter int DW  = 8,
  parameter int WCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ctl_present,
  input  logic [2:0]     bus_sel,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           fdc_wr,
  output logic           fdc_rd,
  output logic [1:0]     fdc_addr,
  output logic [DW-1:0]  fdc_wdata,
  input  logic [DW-1:0]  fdc_rdata,
  input  logic           fdc_irq,
  input  logic           fdc_drq,
  input  logic [WCW-1:0] dma_words,
  input  logic           dma_busy,
  input  logic           media_dd,
  input  logic           drive_sd,
  output logic           dma_fixsrc,
  output logic           dma_start,
  output logic           dma_xfer,
  output logic           irq_out,
  output logic           cmd_is_type1,
  output logic           side_sel
);
  localparam logic [DW-1:0] ALL1 = '1;
  localparam logic [DW-2:0] HI1  = '1;

  logic    wr_ok, rd_ok, to_core;
  logic    drq_q, irq_q, mask_q;
  regsel_e sel;

  assign sel     = regsel_e'(bus_sel);
  assign wr_ok   = bus_wr && ctl_present;
  assign rd_ok   = bus_rd && ctl_present;
  assign to_core = !bus_sel[2];

  assign fdc_wr   = wr_ok && to_core;
  assign fdc_rd   = rd_ok && to_core;
  assign fdc_addr = bus_sel[1:0];

  fdcb_track_xlat #(.DW(DW)) u_xlat (
    .is_track (sel == RS_TRACK),
    .media_dd (media_dd),
    .drive_sd (drive_sd),
    .din      (bus_wdata),
    .dout     (fdc_wdata)
  );

  fdcb_cmd_decode #(.WCW(WCW)) u_cmd (
    .clk          (clk),
    .rst          (rst),
    .cmd_we       (wr_ok && (sel == RS_CMD)),
    .cmd_val      (bus_wdata[7:0]),
    .dma_words    (dma_words),
    .dma_busy     (dma_busy),
    .cmd_is_type1 (cmd_is_type1),
    .dma_fixsrc   (dma_fixsrc),
    .dma_start    (dma_start)
  );

  fdcb_irq_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .fdc_drq  (fdc_drq),
    .fdc_irq  (fdc_irq),
    .dma_busy (dma_busy),
    .mask_we  (wr_ok && (sel == RS_MASK)),
    .mask_val (bus_wdata[0]),
    .drq_q    (drq_q),
    .irq_q    (irq_q),
    .mask_q   (mask_q),
    .irq_out  (irq_out),
    .dma_xfer (dma_xfer)
  );

  always_ff @(posedge clk) begin
    if (rst) side_sel <= 1'b0;
    else if (wr_ok && (sel == RS_SIDE)) side_sel <= bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= ALL1;
    end else if (bus_rd) begin
      if (!ctl_present) bus_rdata <= ALL1;
      else begin
        case (sel)
          RS_CMD, RS_TRACK, RS_SECTOR, RS_DATA: bus_rdata <= fdc_rdata;
          RS_SIDE:  bus_rdata <= {HI1, side_sel};
          RS_FLAGS: bus_rdata <= {drq_q, irq_q, HI1[DW-3:0]};
          RS_MASK:  bus_rdata <= {HI1, mask_q};
          default:  bus_rdata <= ALL1;
        endcase
      end
    end
  end
endmodule

// File: rtl/fdcb_checks.sv
module fdcb_checks (
  input logic       clk,
  input logic       rst,
  input logic       ctl_present,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [2:0] bus_sel,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       fdc_irq,
  input logic       mask_q,
  input logic       irq_out,
  input logic       dma_fixsrc,
  input logic       dma_start,
  input logic       dma_xfer,
  input logic       cmd_is_type1,
  input logic       side_sel
);
  p_fix_then_start_r3: assert property (@(posedge clk) disable iff (rst)
    dma_fixsrc |=> dma_start);
  p_start_after_fix_r3: assert property (@(posedge clk) disable iff (rst)
    dma_start |-> $past(dma_fixsrc));
  p_xfer_single_r6: assert property (@(posedge clk) disable iff (rst)
    dma_xfer |=> !dma_xfer);
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(fdc_irq && !mask_q));
  p_absent_reads_ones_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !ctl_present) |=> (bus_rdata == 8'hFF));
  p_type1_flag_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ctl_present && bus_sel == 3'd0) |=> (cmd_is_type1 == !$past(bus_wdata[7])));
  p_side_only_by_write_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(side_sel) |-> $past(bus_wr && ctl_present && bus_sel == 3'd4));
endmodule

bind fdc_host_bridge fdcb_checks u_chk (
  .clk          (clk),
  .rst          (rst),
  .ctl_present  (ctl_present),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_sel      (bus_sel),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .fdc_irq      (fdc_irq),
  .mask_q       (mask_q),
  .irq_out      (irq_out),
  .dma_fixsrc   (dma_fixsrc),
  .dma_start    (dma_start),
  .dma_xfer     (dma_xfer),
  .cmd_is_type1 (cmd_is_type1),
  .side_sel     (side_sel)
);

// File: tb/tb_fdc_host_bridge.sv
`timescale 1ns/1ps
module tb_fdc_host_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_present = 1'b1;
  logic [2:0]  bus_sel = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        fdc_wr, fdc_rd;
  logic [1:0]  fdc_addr;
  logic [7:0]  fdc_wdata, fdc_rdata;
  logic        fdc_irq = 1'b0, fdc_drq = 1'b0;
  logic [15:0] dma_words = 16'd10;
  logic        dma_busy = 1'b0, media_dd = 1'b0, drive_sd = 1'b0;
  logic        dma_fixsrc, dma_start, dma_xfer, irq_out, cmd_is_type1, side_sel;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] core_reg [4];
  logic [7:0] rv;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) for (int i = 0; i < 4; i++) core_reg[i] <= 8'h00;
    else if (fdc_wr) core_reg[fdc_addr] <= fdc_wdata;
  end
  assign fdc_rdata = core_reg[fdc_addr];

  fdc_host_bridge dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [7:0] d);
    bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [7:0] d);
    bus_sel = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check(cmd_is_type1 == 0 && side_sel == 0 && irq_out == 0, "R10", {cmd_is_type1, side_sel, irq_out}, 0);
    check(!dma_fixsrc && !dma_start && !dma_xfer, "R10", {dma_fixsrc, dma_start, dma_xfer}, 0);
    check(bus_rdata == 8'hFF, "R10", bus_rdata, 8'hFF);
    bread(3'd5, rv);
    check(rv == 8'h3F, "R10 flags", rv, 8'h3F);

    // R1 R2 R3 sweep of all command codes with an armed, idle channel
    for (int c = 0; c < 256; c++) begin
      bit exp_dma;
      exp_dma = ((c >= 8'h80) && (c < 8'hD0)) || (c >= 8'hE0);
      bwrite(3'd0, c[7:0]);
      check(cmd_is_type1 == (c < 8'h80), "R1", cmd_is_type1, c < 8'h80);
      check(dma_fixsrc == exp_dma && !dma_start, "R2", {dma_fixsrc, dma_start}, {exp_dma, 1'b0});
      @(negedge clk);
      check(dma_start == exp_dma && !dma_fixsrc, "R3", {dma_fixsrc, dma_start}, {1'b0, exp_dma});
      @(negedge clk);
      check(!dma_start, "R3 single", dma_start, 0);
    end

    // R2 disqualifying word counts and busy channel
    for (int k = 0; k < 4; k++) begin
      bit exp_go;
      dma_words = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'hFFFE : 16'h0001;
      exp_go = (k >= 2);
      bwrite(3'd0, 8'h80);
      check(dma_fixsrc == exp_go, "R2 words", dma_fixsrc, exp_go);
      @(negedge clk); @(negedge clk);
    end
    dma_busy = 1'b1;
    bwrite(3'd0, 8'hE4);
    check(!dma_fixsrc, "R2 busy", dma_fixsrc, 0);
    @(negedge clk);
    check(!dma_start, "R2 busy", dma_start, 0);
    dma_busy = 1'b0;

    // R11 forwarding of sector, data and command
    bwrite(3'd2, 8'h5A); bwrite(3'd3, 8'hC3);
    bread(3'd2, rv); check(rv == 8'h5A, "R11 sector", rv, 8'h5A);
    bread(3'd3, rv); check(rv == 8'hC3, "R11 data", rv, 8'hC3);
    bread(3'd0, rv); check(rv == 8'hE4, "R11 command", rv, 8'hE4);

    // R8 track translation over the four density combinations
    for (int k = 0; k < 4; k++) begin
      logic [7:0] exp_t;
      media_dd = k[0]; drive_sd = k[1];
      exp_t = (k == 3) ? 8'h4A : 8'h25;
      bwrite(3'd1, 8'h25);
      bread(3'd1, rv);
      check(rv == exp_t, "R8", rv, exp_t);
    end
    media_dd = 0; drive_sd = 0;

    // R7 side register
    bwrite(3'd4, 8'hFF);
    check(side_sel == 1, "R7", side_sel, 1);
    bread(3'd4, rv); check(rv == 8'hFF, "R7", rv, 8'hFF);
    bwrite(3'd4, 8'h02);
    check(side_sel == 0, "R7", side_sel, 0);
    bread(3'd4, rv); check(rv == 8'hFE, "R7", rv, 8'hFE);

    // R4 flag byte for all DRQ/IRQ combinations
    for (int k = 0; k < 4; k++) begin
      logic [7:0] exp_f;
      fdc_drq = k[1]; fdc_irq = k[0];
      exp_f = {k[1], k[0], 6'h3F};
      @(negedge clk);
      bread(3'd5, rv);
      check(rv == exp_f, "R4", rv, exp_f);
    end
    fdc_drq = 0; fdc_irq = 0;
    @(negedge clk);

    // R4 same cycle: read as lines rise returns old flags
    fdc_drq = 1; fdc_irq = 1;
    bread(3'd5, rv); check(rv == 8'h3F, "R4 same-cycle", rv, 8'h3F);
    bread(3'd5, rv); check(rv == 8'hFF, "R4 next read", rv, 8'hFF);

    // R5 masking
    check(irq_out == 0, "R5 masked after reset", irq_out, 0);
    bread(3'd6, rv); check(rv == 8'hFF, "R5 mask read", rv, 8'hFF);
    bwrite(3'd6, 8'h00);
    @(negedge clk);
    check(irq_out == 1, "R5 unmasked", irq_out, 1);
    fdc_irq = 0;
    @(negedge clk);
    check(irq_out == 0, "R5 irq low", irq_out, 0);
    bwrite(3'd6, 8'h01);
    fdc_irq = 1;
    @(negedge clk); @(negedge clk);
    check(irq_out == 0, "R5 remasked", irq_out, 0);
    fdc_irq = 0; fdc_drq = 0;
    @(negedge clk);

    // R6 transfer pulse only while busy
    dma_busy = 1; fdc_drq = 1;
    @(negedge clk);
    check(dma_xfer == 1, "R6 pulse", dma_xfer, 1);
    @(negedge clk);
    check(dma_xfer == 0, "R6 one cycle", dma_xfer, 0);
    fdc_drq = 0; dma_busy = 0;
    @(negedge clk);
    fdc_drq = 1;
    @(negedge clk);
    check(dma_xfer == 0, "R6 idle channel", dma_xfer, 0);
    fdc_drq = 0;
    @(negedge clk);

    // R2 R6 same cycle: start command while DRQ rises on a busy channel
    dma_busy = 1; dma_words = 16'd8; fdc_drq = 1;
    bwrite(3'd0, 8'h88);
    check(dma_xfer == 1 && dma_fixsrc == 0, "R6 with command", {dma_xfer, dma_fixsrc}, 2'b10);
    fdc_drq = 0; dma_busy = 0;
    @(negedge clk);

    // R9 absent controller
    ctl_present = 0;
    for (int a = 0; a < 8; a++) begin
      bread(a[2:0], rv);
      check(rv == 8'hFF, "R9 read", rv, 8'hFF);
    end
    bwrite(3'd2, 8'h11);
    bwrite(3'd4, 8'h01);
    bwrite(3'd0, 8'h90);
    check(dma_fixsrc == 0 && side_sel == 0, "R9 write", {dma_fixsrc, side_sel}, 0);
    ctl_present = 1;
    bread(3'd2, rv); check(rv == 8'h5A, "R9 sector kept", rv, 8'h5A);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule